// File: doc/BRIEF.md
# MDIO Management Frame Decoder

This block is the target side of a two-wire management bus. It runs on the system clock and treats the management clock and data lines as asynchronous inputs. Each line passes through a synchronizer, and the block detects both edges of the management clock. From these edges it decodes clause-22 frames: a preamble of ones, a start pattern, a two-bit opcode, a five-bit device address, a five-bit register address, a two-cycle turnaround and sixteen data bits.

One device answers at the address set by a parameter. When a read frame names that address, the block fetches one word from an attached register port and drives it onto the data line through an output enable. When a write frame names that address, the block issues a single write strobe with the collected word after the last data bit has arrived. A read addressed to any other device returns all ones. A write addressed to any other device changes nothing.

Progress through a frame is counted in management-clock edges. Both rising and falling edges advance the count.

Top module: `mdio_frame_decoder`

## Requirements
- R1: After synchronous reset the output enable is low, no read or write strobe is issued, and the decoder waits in the preamble phase with its edge count at zero.
- R2: The decoder leaves the preamble only on a rising management-clock edge where data is sampled low and at least 64 clock edges (32 cycles) have been counted since reset or since the previous frame ended. A low sample that arrives earlier is ignored.
- R3: The start phase lasts one clock cycle. If data is sampled low on its rising edge, start_warn pulses for one system clock. The frame still continues and completes.
- R4: The opcode (2 bits), the device address (5 bits) and the register address (5 bits) are shifted in, in that order, MSB first, on rising edges. reg_addr carries the captured register address.
- R5: On the rising edge that ends the two-cycle turnaround, opcode 2'b10 (read) raises mdio_oe. If the device address matches, reg_rd_en pulses in the same system cycle with reg_addr valid, and the word is captured. The word then leaves MSB first: the first data bit is placed at turnaround end, and every falling edge presents the next bit, so the bus is valid before each of the 16 data rising edges.
- R6: A read whose device address differs from PHY_ADDR returns 16'hFFFF on the data line, and reg_rd_en stays low.
- R7: A write frame collects 16 data bits MSB first on rising edges. If the device address matches, exactly one reg_wr_en pulse follows the 16th data rising edge, carrying reg_addr and reg_wr_data. If the address does not match, no strobe is issued.
- R8: Any opcode other than 2'b10 (including 2'b00, 2'b01 and 2'b11) is handled as a write.
- R9: After the 16th data rising edge, mdio_oe is released and the decoder returns to the preamble phase with its edge count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mdc_in | input | 1 | Management clock, asynchronous to clk |
| mdio_in | input | 1 | Management data line as seen at the pad |
| mdio_out | output | 1 | Data value driven during a read |
| mdio_oe | output | 1 | Drive enable for mdio_out |
| reg_addr | output | 5 | Register address of the current frame |
| reg_rd_en | output | 1 | One-cycle read strobe to the register port |
| reg_rd_data | input | 16 | Register word returned combinationally for reg_addr |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 16 | Word written with reg_wr_en |
| start_warn | output | 1 | Pulse when the start bit is sampled low |

## Verification
The bench writes a distinct pattern into every register address and then reads every one back. An error in shift direction, bit order or edge choice therefore shows up as a wrong word, a word off by one bit, or a missing strobe.

The first frame after reset carries exactly the minimum preamble, so an off-by-one edge threshold loses that frame. A later burst sends a low bit after only 20 ones. A decoder that leaves the preamble too early would decode a phantom write of all ones to register 31, which the strobe counter and the later read-back would both expose.

Frames addressed to a neighbouring device address must return all ones with no read strobe, and must leave the register untouched. The bench also covers the reserved opcodes, which must commit as writes, and a frame with a bad start bit, which must raise the warning and still write its data.

// File: rtl/mdio_dec_pkg.sv
package mdio_dec_pkg;

    parameter int MD_ADDR_W = 5;
    parameter int MD_DATA_W = 16;
    parameter int MD_OPC_W  = 2;

    localparam logic [MD_OPC_W-1:0] OPC_RD = 2'b10;

    typedef enum logic [2:0] {
        PH_PRE,
        PH_START,
        PH_OPC,
        PH_DEV,
        PH_REG,
        PH_TURN,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic sdata;
    } mgmt_edge_t;

    typedef struct packed {
        logic [MD_OPC_W-1:0]  opc;
        logic [MD_ADDR_W-1:0] dev;
        logic [MD_ADDR_W-1:0] regn;
    } hdr_t;

    function automatic logic dev_hit(input logic [MD_ADDR_W-1:0] got,
                                     input logic [MD_ADDR_W-1:0] mine);
        return got == mine;
    endfunction

    function automatic logic [MD_ADDR_W-1:0] shin5(input logic [MD_ADDR_W-1:0] v,
                                                   input logic b);
        return {v[MD_ADDR_W-2:0], b};
    endfunction

endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= '0;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mdio_edge.sv
module mdio_edge
    import mdio_dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mdc_s,
    input  logic       mdio_s,
    output mgmt_edge_t ev
);
    logic mdc_prev;

    always_ff @(posedge clk) begin
        if (rst) mdc_prev <= 1'b0;
        else     mdc_prev <= mdc_s;
    end

    always_comb begin
        ev.rise  = mdc_s & ~mdc_prev;
        ev.fall  = ~mdc_s & mdc_prev;
        ev.sdata = mdio_s;
    end
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_dec_pkg::*;
#(
    parameter logic [MD_ADDR_W-1:0] PHY_ADDR        = 5'd1,
    parameter int                   PREAMBLE_CYCLES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  mgmt_edge_t           ev,
    input  logic [MD_DATA_W-1:0] rd_word,
    output logic                 drv_val,
    output logic                 drv_en,
    output logic [MD_ADDR_W-1:0] regn,
    output logic                 rd_stb,
    output logic                 wr_stb,
    output logic [MD_DATA_W-1:0] wr_word,
    output logic                 warn,
    output phase_e               phase_o
);
    localparam int PRE_EDGES  = 2 * PREAMBLE_CYCLES;
    localparam int DATA_EDGES = 2 * MD_DATA_W;
    localparam int CNT_LIM    = (PRE_EDGES > DATA_EDGES) ? PRE_EDGES : DATA_EDGES;
    localparam int CNT_W      = $clog2(CNT_LIM + 1);

    localparam logic [CNT_W-1:0] E_PRE   = CNT_W'(PRE_EDGES);
    localparam logic [CNT_W-1:0] E_START = CNT_W'(2);
    localparam logic [CNT_W-1:0] E_OPC   = CNT_W'(2 * MD_OPC_W);
    localparam logic [CNT_W-1:0] E_ADDR  = CNT_W'(2 * MD_ADDR_W);
    localparam logic [CNT_W-1:0] E_TURN  = CNT_W'(4);
    localparam logic [CNT_W-1:0] E_DATA  = CNT_W'(DATA_EDGES);
    localparam logic [CNT_W-1:0] E_SAT   = CNT_W'(CNT_LIM);

    phase_e               phase;
    logic [CNT_W-1:0]     cnt, cnt_inc;
    hdr_t                 hdr;
    logic [MD_DATA_W-1:0] sh;
    logic                 is_rd;
    logic                 any_edge, hit, turn_end;

    assign any_edge = ev.rise | ev.fall;
    assign hit      = dev_hit(hdr.dev, PHY_ADDR);
    assign cnt_inc  = (cnt == E_SAT) ? cnt : cnt + CNT_W'(1);
    assign turn_end = (phase == PH_TURN) && ev.rise && (cnt_inc == E_TURN);

    // read fetch happens in the very cycle the word is captured
    assign rd_stb  = turn_end && (hdr.opc == OPC_RD) && hit;
    assign regn    = hdr.regn;
    assign wr_word = sh;
    assign phase_o = phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_PRE;
            cnt     <= '0;
            hdr     <= '0;
            sh      <= '0;
            is_rd   <= 1'b0;
            drv_en  <= 1'b0;
            drv_val <= 1'b0;
            wr_stb  <= 1'b0;
            warn    <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            warn   <= 1'b0;
            if (any_edge) begin
                cnt <= cnt_inc;
                unique case (phase)
                    PH_PRE: begin
                        if (ev.rise && cnt_inc >= E_PRE && !ev.sdata) begin
                            cnt   <= '0;
                            phase <= PH_START;
                        end
                    end
                    PH_START: begin
                        if (ev.rise) begin
                            if (!ev.sdata) warn <= 1'b1;
                            if (cnt_inc == E_START) begin
                                cnt     <= '0;
                                hdr.opc <= '0;
                                phase   <= PH_OPC;
                            end
                        end
                    end
                    PH_OPC: begin
                        if (ev.rise) begin
                            hdr.opc <= {hdr.opc[MD_OPC_W-2:0], ev.sdata};
                            if (cnt_inc == E_OPC) begin
                                cnt     <= '0;
                                hdr.dev <= '0;
                                phase   <= PH_DEV;
                            end
                        end
                    end
                    PH_DEV: begin
                        if (ev.rise) begin
                            hdr.dev <= shin5(hdr.dev, ev.sdata);
                            if (cnt_inc == E_ADDR) begin
                                cnt      <= '0;
                                hdr.regn <= '0;
                                phase    <= PH_REG;
                            end
                        end
                    end
                    PH_REG: begin
                        if (ev.rise) begin
                            hdr.regn <= shin5(hdr.regn, ev.sdata);
                            if (cnt_inc == E_ADDR) begin
                                cnt   <= '0;
                                phase <= PH_TURN;
                            end
                        end
                    end
                    PH_TURN: begin
                        if (turn_end) begin
                            cnt   <= '0;
                            phase <= PH_DATA;
                            if (hdr.opc == OPC_RD) begin
                                is_rd   <= 1'b1;
                                drv_en  <= 1'b1;
                                sh      <= hit ? rd_word : '1;
                                drv_val <= hit ? rd_word[MD_DATA_W-1] : 1'b1;
                            end else begin
                                is_rd <= 1'b0;
                            end
                        end
                    end
                    PH_DATA: begin
                        if (ev.fall) begin
                            if (is_rd) begin
                                drv_val <= sh[MD_DATA_W-1];
                                sh      <= {sh[MD_DATA_W-2:0], 1'b0};
                            end
                        end else begin
                            if (!is_rd) sh <= {sh[MD_DATA_W-2:0], ev.sdata};
                            if (cnt_inc == E_DATA) begin
                                cnt    <= '0;
                                phase  <= PH_PRE;
                                drv_en <= 1'b0;
                                is_rd  <= 1'b0;
                                if (!is_rd && hit) wr_stb <= 1'b1;
                            end
                        end
                    end
                    default: phase <= PH_PRE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdio_frame_decoder.sv
module mdio_frame_decoder
    import mdio_dec_pkg::*;
#(
    parameter logic [MD_ADDR_W-1:0] PHY_ADDR        = 5'd1,
    parameter int                   PREAMBLE_CYCLES = 32,
    parameter int                   SYNC_STAGES     = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mdc_in,
    input  logic                 mdio_in,
    output logic                 mdio_out,
    output logic                 mdio_oe,
    output logic [MD_ADDR_W-1:0] reg_addr,
    output logic                 reg_rd_en,
    input  logic [MD_DATA_W-1:0] reg_rd_data,
    output logic                 reg_wr_en,
    output logic [MD_DATA_W-1:0] reg_wr_data,
    output logic                 start_warn
);
    logic [1:0] pins_s;
    mgmt_edge_t edges;
    phase_e     cur_phase;

    mdio_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({mdc_in, mdio_in}),
        .q   (pins_s)
    );

    mdio_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .mdc_s  (pins_s[1]),
        .mdio_s (pins_s[0]),
        .ev     (edges)
    );

    mdio_frame_fsm #(
        .PHY_ADDR        (PHY_ADDR),
        .PREAMBLE_CYCLES (PREAMBLE_CYCLES)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (edges),
        .rd_word (reg_rd_data),
        .drv_val (mdio_out),
        .drv_en  (mdio_oe),
        .regn    (reg_addr),
        .rd_stb  (reg_rd_en),
        .wr_stb  (reg_wr_en),
        .wr_word (reg_wr_data),
        .warn    (start_warn),
        .phase_o (cur_phase)
    );
endmodule

// File: rtl/mdio_frame_decoder_chk.sv
module mdio_frame_decoder_chk
    import mdio_dec_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   mdio_out,
    input logic   mdio_oe,
    input logic   reg_rd_en,
    input logic   reg_wr_en,
    input logic   mdc_fall,
    input phase_e cur_phase
);
    // R1
    oe_low_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !mdio_oe);

    // R5
    rd_starts_drive_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd_en |=> mdio_oe);

    // R5
    drive_moves_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe && $past(mdio_oe) && !$past(mdc_fall)) |-> $stable(mdio_out));

    // R7
    wr_not_while_driving_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> !mdio_oe);

    // R7
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd_en && reg_wr_en));

    // R9
    release_back_to_preamble_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mdio_oe) |-> (cur_phase == PH_PRE));
endmodule

bind mdio_frame_decoder mdio_frame_decoder_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .reg_rd_en (reg_rd_en),
    .reg_wr_en (reg_wr_en),
    .mdc_fall  (edges.fall),
    .cur_phase (cur_phase)
);

// File: tb/mdio_frame_decoder_tb_top.sv
module mdio_frame_decoder_tb_top;
    localparam logic [4:0] MY_DEV = 5'd31;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mdc = 1'b0;
    logic        drv = 1'b1;
    logic        mdio_bus;
    logic        mdio_out, mdio_oe;
    logic [4:0]  reg_addr;
    logic        reg_rd_en, reg_wr_en, start_warn;
    logic [15:0] reg_rd_data, reg_wr_data;

    logic [15:0] mem [32];
    int          wr_cnt = 0, rd_cnt = 0, warn_cnt = 0;
    logic [4:0]  last_addr;
    logic [15:0] last_data;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    assign mdio_bus    = mdio_oe ? mdio_out : drv;
    assign reg_rd_data = mem[reg_addr];

    mdio_frame_decoder #(.PHY_ADDR(MY_DEV)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .mdc_in      (mdc),
        .mdio_in     (mdio_bus),
        .mdio_out    (mdio_out),
        .mdio_oe     (mdio_oe),
        .reg_addr    (reg_addr),
        .reg_rd_en   (reg_rd_en),
        .reg_rd_data (reg_rd_data),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .start_warn  (start_warn)
    );

    always @(negedge clk) begin
        if (reg_wr_en) begin
            mem[reg_addr] <= reg_wr_data;
            wr_cnt    <= wr_cnt + 1;
            last_addr <= reg_addr;
            last_data <= reg_wr_data;
        end
        if (reg_rd_en)  rd_cnt   <= rd_cnt + 1;
        if (start_warn) warn_cnt <= warn_cnt + 1;
    end

    function automatic logic [15:0] pat(input logic [4:0] r);
        return {r, ~r, r, 1'b1};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cyc(input logic b, output logic s, output logic oe);
        mdc = 1'b0;
        tick(4);
        drv = b;
        tick(4);
        s  = mdio_bus;
        oe = mdio_oe;
        mdc = 1'b1;
        tick(8);
    endtask

    task automatic frame(input int pre, input logic st1, input logic [1:0] opc,
                         input logic [4:0] dev, input logic [4:0] rg,
                         input logic [15:0] wd, output logic [15:0] rd,
                         output int oe_bits);
        logic s, o;
        oe_bits = 0;
        for (int i = 0; i < pre; i++) cyc(1'b1, s, o);
        cyc(1'b0, s, o);
        cyc(st1, s, o);
        for (int i = 1; i >= 0; i--) cyc(opc[i], s, o);
        for (int i = 4; i >= 0; i--) cyc(dev[i], s, o);
        for (int i = 4; i >= 0; i--) cyc(rg[i], s, o);
        cyc(1'b1, s, o);
        cyc(1'b0, s, o);
        for (int i = 15; i >= 0; i--) begin
            cyc(wd[i], s, o);
            rd[i] = s;
            if (o) oe_bits++;
        end
        drv = 1'b1;
    endtask

    initial begin
        logic [15:0] rd;
        int          oeb, w0, r0;
        for (int i = 0; i < 32; i++) mem[i] = 16'h0000;
        tick(5);
        rst = 1'b0;
        tick(3);
        // R1 reset state
        chk(mdio_oe == 1'b0, "R1 oe after reset", 32'(mdio_oe), 0);
        chk(wr_cnt == 0 && rd_cnt == 0, "R1 no strobes", 32'(wr_cnt + rd_cnt), 0);

        // R7 R4 R2: write sweep, first frame uses the minimum preamble
        for (int r = 0; r < 32; r++) begin
            w0 = wr_cnt;
            frame(32, 1'b1, 2'b01, MY_DEV, 5'(r), pat(5'(r)), rd, oeb);
            chk(wr_cnt == w0 + 1, "R7 R2 one write strobe", 32'(wr_cnt - w0), 1);
            chk(last_addr == 5'(r), "R4 write register address", 32'(last_addr), 32'(r));
            chk(last_data == pat(5'(r)), "R7 write data", 32'(last_data), 32'(pat(5'(r))));
            chk(oeb == 0, "R7 no drive during write", 32'(oeb), 0);
        end

        // R5 R9: read sweep
        for (int r = 0; r < 32; r++) begin
            r0 = rd_cnt;
            frame(32, 1'b1, 2'b10, MY_DEV, 5'(r), 16'h0000, rd, oeb);
            chk(rd == pat(5'(r)), "R5 read data", 32'(rd), 32'(pat(5'(r))));
            chk(rd_cnt == r0 + 1, "R5 one read strobe", 32'(rd_cnt - r0), 1);
            chk(oeb == 16, "R5 drive over data bits", 32'(oeb), 16);
            chk(mdio_oe == 1'b0, "R9 drive released", 32'(mdio_oe), 0);
        end
        chk(warn_cnt == 0, "R3 no warning on good start", 32'(warn_cnt), 0);

        // R6: read of a neighbouring device address
        r0 = rd_cnt;
        frame(32, 1'b1, 2'b10, 5'd30, 5'd4, 16'h0000, rd, oeb);
        chk(rd == 16'hFFFF, "R6 foreign read value", 32'(rd), 32'hFFFF);
        chk(rd_cnt == r0, "R6 no read strobe", 32'(rd_cnt - r0), 0);

        // R7: write to a foreign device, then read back unchanged
        w0 = wr_cnt;
        frame(32, 1'b1, 2'b01, 5'd30, 5'd4, 16'h1234, rd, oeb);
        chk(wr_cnt == w0, "R7 foreign write ignored", 32'(wr_cnt - w0), 0);
        frame(32, 1'b1, 2'b10, MY_DEV, 5'd4, 16'h0000, rd, oeb);
        chk(rd == pat(5'd4), "R7 register kept", 32'(rd), 32'(pat(5'd4)));

        // R8: reserved opcodes commit as writes
        w0 = wr_cnt;
        frame(32, 1'b1, 2'b00, MY_DEV, 5'd7, 16'hA5C3, rd, oeb);
        chk(wr_cnt == w0 + 1 && last_data == 16'hA5C3, "R8 opcode 00 writes",
            32'(last_data), 32'hA5C3);
        frame(32, 1'b1, 2'b11, MY_DEV, 5'd8, 16'h3C5A, rd, oeb);
        chk(wr_cnt == w0 + 2 && last_addr == 5'd8, "R8 opcode 11 writes",
            32'(last_addr), 8);
        frame(32, 1'b1, 2'b10, MY_DEV, 5'd7, 16'h0000, rd, oeb);
        chk(rd == 16'hA5C3, "R8 readback", 32'(rd), 32'hA5C3);

        // R3: bad start bit warns but the frame completes
        w0 = wr_cnt;
        frame(32, 1'b0, 2'b01, MY_DEV, 5'd9, 16'h0F0F, rd, oeb);
        chk(warn_cnt == 1, "R3 start warning", 32'(warn_cnt), 1);
        chk(wr_cnt == w0 + 1 && last_data == 16'h0F0F, "R3 frame still writes",
            32'(last_data), 32'h0F0F);

        // R2: a low bit after a short preamble is ignored
        begin
            logic s, o;
            w0 = wr_cnt;
            for (int i = 0; i < 20; i++) cyc(1'b1, s, o);
            cyc(1'b0, s, o);
            for (int i = 0; i < 40; i++) cyc(1'b1, s, o);
            chk(wr_cnt == w0, "R2 short preamble ignored", 32'(wr_cnt - w0), 0);
        end
        frame(32, 1'b1, 2'b10, MY_DEV, 5'd31, 16'h0000, rd, oeb);
        chk(rd == pat(5'd31), "R2 register 31 untouched", 32'(rd), 32'(pat(5'd31)));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule